// File: doc/BRIEF.md
# Knob-Driven Buffer Length Tracker

This block turns a noisy stream of 10-bit converter readings, taken from a front-panel knob, into a steady 16-bit length for an audio sample buffer. Readings are summed in fixed blocks of 256. Each finished block gives one candidate length, equal to the sum divided by four. A candidate that is too short is raised to a floor value. The candidate becomes the new goal length only if it differs from the current goal by enough to count as a real knob movement. A goal length is always even.

The length that the buffer actually uses does not jump to the goal. It moves toward the goal by a fixed step of 2, once per audio sample strobe, so a turn of the knob glides the loop length instead of changing it abruptly. The converter itself and the logic that starts its conversions sit outside this block. The block only sees result-valid pulses with their data and the per-sample strobe.

Top module: `knob_len_tracker`

## Requirements
- R1: After reset, `active_size` is 0x0600 and the goal length equals it. The reading sum and the reading count start at zero, so sample strobes alone leave `active_size` at 0x0600.
- R2: Each cycle with `adc_valid` high adds `adc_code` to a 24-bit sum. The 256th reading closes a block and forms a 16-bit candidate, equal to the sum shifted right by 2. The sum and count then restart from zero.
- R3: Fewer than 256 readings produce no candidate and leave the goal length unchanged.
- R4: A candidate below the floor of 4·65536/FADE_STEP (2048 with the default FADE_STEP of 128) is replaced by the floor before it is compared.
- R5: The goal length takes the candidate only when |candidate − goal| is at least 64. This difference is computed in 17 bits. A difference of 63 or less discards the candidate.
- R6: When the goal length is updated, bit 0 of the candidate is cleared, so the goal is always even.
- R7: On each cycle with `sample_tick` high, `active_size` moves 2 toward the goal: up by 2 if it is below the goal, down by 2 if above. It holds if the two are equal.
- R8: `active_size` changes only on cycles with `sample_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| adc_valid | input | 1 | One-cycle pulse: `adc_code` holds a new reading |
| adc_code | input | 10 | Unsigned knob reading |
| sample_tick | input | 1 | One pulse per audio sample period |
| active_size | output | 16 | Buffer length currently in use |

## Verification
Blocks of constant readings set the candidate to exactly 64 times the reading. Blocks that mix two adjacent values move the candidate by quarter steps. This makes it possible to reach an odd candidate (R6) and a difference of exactly 63 or exactly 64 from the goal (R5). Low readings test the floor clamp, both when the clamped value is a real change and when it equals the goal (R4). A partial block, a block completed across a pause, and a reset in the middle of a block separate correct counting from leftover sum or count (R2, R3, R1). Every goal change is followed through the slew: the output is sampled before any strobe, at the midpoint and at arrival, and one strobe past arrival. These samples check the step size, the direction and the hold (R7, R8).

// File: rtl/knob_len_pkg.sv
package knob_len_pkg;

    // Direction of the next slew step.
    typedef enum logic [1:0] {
        DIR_HOLD = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DOWN = 2'b10
    } slew_dir_e;

    // Length used by the buffer until the knob is first read.
    localparam int unsigned POWERUP_LEN = 32'h0000_0600;

endpackage

// File: rtl/knob_block_avg.sv
module knob_block_avg #(
    parameter int unsigned CODE_W   = 10,
    parameter int unsigned SUM_W    = 24,
    parameter int unsigned BLK_LOG2 = 8,
    parameter int unsigned SHIFT    = 2,
    parameter int unsigned LEN_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_vld,
    input  logic [CODE_W-1:0] code,
    output logic              cand_vld,
    output logic [LEN_W-1:0]  cand
);
    localparam int unsigned CNT_W = BLK_LOG2;
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    typedef struct packed {
        logic [SUM_W-1:0] sum;
        logic [CNT_W-1:0] cnt;
        logic             vld;
        logic [LEN_W-1:0] cand;
    } avg_st_t;

    avg_st_t          s_d, s_q;
    logic [SUM_W-1:0] sum_next;

    always_comb begin
        s_d      = s_q;
        s_d.vld  = 1'b0;
        sum_next = s_q.sum + SUM_W'(code);
        if (code_vld) begin
            if (s_q.cnt == CNT_LAST) begin
                // block complete: publish candidate and restart
                s_d.cand = LEN_W'(sum_next >> SHIFT);
                s_d.vld  = 1'b1;
                s_d.sum  = '0;
                s_d.cnt  = '0;
            end else begin
                s_d.sum = sum_next;
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cand_vld = s_q.vld;
    assign cand     = s_q.cand;

    // R2: a published candidate always leaves an empty sum and count behind
    a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.vld |-> (s_q.sum == '0 && s_q.cnt == '0));

    // R2: the closing reading of a block yields a candidate next cycle
    a_r2_block_close: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && s_q.cnt == CNT_LAST) |=> s_q.vld);

    // R3: without a reading, no candidate appears
    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !code_vld |=> !s_q.vld);

endmodule

// File: rtl/knob_target_gate.sv
module knob_target_gate #(
    parameter int unsigned LEN_W    = 16,
    parameter int unsigned MIN_LEN  = 2048,
    parameter int unsigned DEADBAND = 64,
    parameter int unsigned INIT_LEN = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cand_vld,
    input  logic [LEN_W-1:0] cand,
    output logic [LEN_W-1:0] goal
);
    localparam int unsigned DIFF_W = LEN_W + 1;
    localparam logic [LEN_W-1:0]  MIN_V  = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0]  INIT_V = LEN_W'(INIT_LEN);
    localparam logic [DIFF_W-1:0] BAND_V = DIFF_W'(DEADBAND);

    typedef struct packed {
        logic [LEN_W-1:0] goal;
    } gate_st_t;

    gate_st_t          s_d, s_q;
    logic [LEN_W-1:0]  clamped;
    logic [DIFF_W-1:0] diff;
    logic [DIFF_W-1:0] mag;
    logic              moved;

    always_comb begin
        s_d     = s_q;
        clamped = (cand < MIN_V) ? MIN_V : cand;
        diff    = {1'b0, clamped} - {1'b0, s_q.goal};
        mag     = diff[DIFF_W-1] ? (~diff + 1'b1) : diff;
        moved   = (mag >= BAND_V);
        if (cand_vld && moved) begin
            s_d.goal = {clamped[LEN_W-1:1], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.goal <= INIT_V;
        else        s_q      <= s_d;
    end

    assign goal = s_q.goal;

    // R5: the goal moves only in response to a candidate
    a_r5_needs_cand: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.goal) |-> $past(cand_vld));

    // R4: a goal that has been updated never lies below the floor
    a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.goal) |-> (s_q.goal >= MIN_V));

    // R6: goal is even
    a_r6_even: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.goal[0] == 1'b0);

endmodule

// File: rtl/knob_len_slew.sv
module knob_len_slew
    import knob_len_pkg::*;
#(
    parameter int unsigned LEN_W    = 16,
    parameter int unsigned STEP     = 2,
    parameter int unsigned INIT_LEN = 1536
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [LEN_W-1:0] goal,
    output logic [LEN_W-1:0] active
);
    localparam logic [LEN_W-1:0] STEP_V = LEN_W'(STEP);
    localparam logic [LEN_W-1:0] INIT_V = LEN_W'(INIT_LEN);

    typedef struct packed {
        logic [LEN_W-1:0] active;
    } slew_st_t;

    slew_st_t         s_d, s_q;
    slew_dir_e        dir;
    logic [LEN_W-1:0] gap;
    logic [LEN_W-1:0] stride;

    always_comb begin
        s_d = s_q;
        if (s_q.active < goal) begin
            dir = DIR_UP;
            gap = goal - s_q.active;
        end else if (s_q.active > goal) begin
            dir = DIR_DOWN;
            gap = s_q.active - goal;
        end else begin
            dir = DIR_HOLD;
            gap = '0;
        end
        // never overshoot the goal
        stride = (gap < STEP_V) ? gap : STEP_V;
        if (tick) begin
            case (dir)
                DIR_UP:   s_d.active = s_q.active + stride;
                DIR_DOWN: s_d.active = s_q.active - stride;
                default:  s_d.active = s_q.active;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.active <= INIT_V;
        else        s_q        <= s_d;
    end

    assign active = s_q.active;

    // R8: no strobe, no movement
    a_r8_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(s_q.active));

    // R7: a strobe with a gap always moves the length
    a_r7_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.active != goal) |=> !$stable(s_q.active));

    // R7: a strobe with no gap holds the length
    a_r7_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.active == goal) |=> $stable(s_q.active));

    // R7: upward steps never exceed the stride
    a_r7_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.active < goal) |=> (s_q.active > $past(s_q.active)
                                         && s_q.active - $past(s_q.active) <= STEP_V));

endmodule

// File: rtl/knob_len_tracker.sv
module knob_len_tracker
    import knob_len_pkg::*;
#(
    parameter int unsigned CODE_W    = 10,
    parameter int unsigned SUM_W     = 24,
    parameter int unsigned BLK_LOG2  = 8,
    parameter int unsigned LEN_W     = 16,
    parameter int unsigned FADE_STEP = 128,
    parameter int unsigned DEADBAND  = 64,
    parameter int unsigned SLEW_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adc_valid,
    input  logic [CODE_W-1:0] adc_code,
    input  logic              sample_tick,
    output logic [LEN_W-1:0]  active_size
);
    // floor keeps room for two crossfade spans on each side
    localparam int unsigned MIN_LEN = 4 * (65536 / FADE_STEP);
    localparam int unsigned SHIFT   = 2;

    logic             cand_vld;
    logic [LEN_W-1:0] cand;
    logic [LEN_W-1:0] goal;

    knob_block_avg #(
        .CODE_W  (CODE_W),
        .SUM_W   (SUM_W),
        .BLK_LOG2(BLK_LOG2),
        .SHIFT   (SHIFT),
        .LEN_W   (LEN_W)
    ) u_avg (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_vld(adc_valid),
        .code    (adc_code),
        .cand_vld(cand_vld),
        .cand    (cand)
    );

    knob_target_gate #(
        .LEN_W   (LEN_W),
        .MIN_LEN (MIN_LEN),
        .DEADBAND(DEADBAND),
        .INIT_LEN(POWERUP_LEN)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand_vld(cand_vld),
        .cand    (cand),
        .goal    (goal)
    );

    knob_len_slew #(
        .LEN_W   (LEN_W),
        .STEP    (SLEW_STEP),
        .INIT_LEN(POWERUP_LEN)
    ) u_slew (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sample_tick),
        .goal  (goal),
        .active(active_size)
    );

endmodule

// File: tb/knob_len_tracker_bench.sv
module knob_len_tracker_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       adc_valid = 1'b0;
    logic [9:0] adc_code = '0;
    logic       sample_tick = 1'b0;
    logic [15:0] active_size;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    knob_len_tracker u_knob_len_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .adc_valid  (adc_valid),
        .adc_code   (adc_code),
        .sample_tick(sample_tick),
        .active_size(active_size)
    );

    // Table: base reading, count of readings at base+1, expected goal, tag.
    localparam int NV = 9;
    localparam int V_BASE [NV] = '{100, 101, 102, 102,  50,    5,    0, 1023,  1022};
    localparam int V_XTRA [NV] = '{  0,   0,   0, 252,  12,    0,    0,    0,     0};
    localparam int V_GOAL [NV] = '{6400, 6464, 6528, 6528, 3202, 2048, 2048, 65472, 65408};
    localparam int V_TAG  [NV] = '{   2,    5,    5,    5,    6,    4,    4,     2,     5};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic feed(input int cnt, input int val);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            adc_valid = 1'b1;
            adc_code  = 10'(val);
        end
        @(negedge clk);
        adc_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic ticks(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            sample_tick = 1'b1;
        end
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int prev;
        int n;
        int half;
        int dirv;
        repeat (3) @(negedge clk);
        // R1: reset value
        check(active_size == 16'h0600, "R1 reset size", active_size, 16'h0600);
        rst_n = 1'b1;
        ticks(5);
        // R1: goal equals active after reset, strobes do not move it
        check(active_size == 16'h0600, "R1 goal matches", active_size, 16'h0600);

        // R3: 255 readings of 40 do not yet form a candidate
        feed(255, 40);
        ticks(10);
        check(active_size == 16'h0600, "R3 partial block", active_size, 16'h0600);
        // R2: the 256th reading completes the block: 256*40/4 = 2560
        feed(1, 40);
        check(active_size == 16'h0600, "R8 no strobe after update", active_size, 1536);
        ticks(256);
        check(active_size == 16'd1536 + 16'd512, "R2 block across pause", active_size, 2048);
        ticks(256);
        check(active_size == 16'd2560, "R2 candidate sum/4", active_size, 2560);

        // R1: reset in mid-block restores length and empties the sum
        feed(100, 1000);
        rst_n = 1'b0;
        @(negedge clk);
        check(active_size == 16'h0600, "R1 mid-run reset", active_size, 16'h0600);
        rst_n = 1'b1;
        @(negedge clk);

        prev = 16'h0600;
        for (int v = 0; v < NV; v++) begin
            feed(V_XTRA[v], V_BASE[v] + 1);
            feed(256 - V_XTRA[v], V_BASE[v]);
            // R8: goal may have moved, but no strobe yet
            check(active_size == 16'(prev), "R8 waits for strobe", active_size, prev);
            n    = (V_GOAL[v] > prev) ? (V_GOAL[v] - prev) / 2 : (prev - V_GOAL[v]) / 2;
            dirv = (V_GOAL[v] > prev) ? 2 : -2;
            half = n / 2;
            if (half > 0) begin
                ticks(half);
                check(active_size == 16'(prev + dirv * half), "R7 midway step",
                      active_size, prev + dirv * half);
            end
            if (n - half > 0) ticks(n - half);
            check(active_size == 16'(V_GOAL[v]), $sformatf("R%0d vector %0d", V_TAG[v], v),
                  active_size, V_GOAL[v]);
            ticks(1);
            check(active_size == 16'(V_GOAL[v]), "R7 hold at goal", active_size, V_GOAL[v]);
            prev = V_GOAL[v];
        end
        summary();
    end

endmodule